// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a 64-entry, 36-bit first-in first-out buffer. A producer writes into it on one clock and a consumer reads from it on a second clock that has no fixed relation to the first. Each side sees only flags that are registered in its own clock. The consumer sees an empty flag and an almost-empty flag. The producer sees a full flag and an almost-full flag. All four flags are active low.

The write and read pointers cross between the two domains in Gray code, each through a two-stage synchronizer. A write therefore becomes visible to the reader after two read-clock edges, and a read frees space for the writer after two write-clock edges. One offset X sets both thresholds: almost-empty trips at X words or fewer, and almost-full trips at 64-X words or more. X is latched from a two-bit select while reset is held. A read moves the oldest word into a registered output stage.

Top module: `afifo_sync_flags`

## Requirements
- R1: While `rst_n` is low (synchronous reset, held for at least four edges of each clock), `empty_n`, `aempty_n` and `full_n` read 0 and `afull_n` reads 1. After release, `full_n` returns to 1 on an empty FIFO.
- R2: Words leave in the order they were written. On a rising `rclk` edge with `ren` high and `empty_n` high, the oldest word is loaded into `rdata`. `rdata` holds that value until the next accepted read.
- R3: A read requested while `empty_n` is 0 is ignored. `rdata` keeps its value, and the read pointer does not move.
- R4: A write requested while `full_n` is 0 is ignored, and the word is not stored.
- R5: Once settled, `aempty_n` is 0 when the FIFO holds X or fewer words and 1 when it holds X+1 or more.
- R6: Once settled, `afull_n` is 0 when the FIFO holds 64-X or more words and 1 when it holds 63-X or fewer.
- R7: X is taken from `ofs_sel` only while reset is held. Code 2'b00 gives 16, 2'b01 gives 2, 2'b10 gives 8 and 2'b11 gives 4. Changing `ofs_sel` after reset has no effect on the thresholds.
- R8: After a write into an empty FIFO, `empty_n` is still 0 after the first rising `rclk` edge and is 1 after the second.
- R9: After a read from a full FIFO, `full_n` is still 0 after the first rising `wclk` edge and is 1 after the second.
- R10: Once settled, `full_n` is 0 exactly when 64 words are held, and `empty_n` is 1 exactly when at least one word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously by both domains |
| ofs_sel | input | 2 | Threshold offset select, latched during reset |
| wen | input | 1 | Write request |
| wdata | input | 36 | Write data |
| full_n | output | 1 | Low when no entry is free (write domain) |
| afull_n | output | 1 | Low when 64-X or more words are held (write domain) |
| ren | input | 1 | Read request |
| rdata | output | 36 | Registered read data |
| empty_n | output | 1 | Low when no word is available (read domain) |
| aempty_n | output | 1 | Low when X or fewer words are held (read domain) |

## Verification
A read pointer that skips or sticks shows up on the very next accepted read, as a wrong or repeated word on `rdata`. A pointer that runs wrong in either domain shifts the word count that each side computes. That error surfaces as a threshold flag flipping one word early or late, or as a lost or duplicated entry once the buffer is drained. A fault in the synchronizer chain changes the flag latency, so it appears within two edges of the opposite clock after a single write or read. A wrong offset latch shows up as `aempty_n` and `afull_n` both moving at the wrong fill levels.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;

    localparam int unsigned DATA_W_DEF = 36;
    localparam int unsigned ADDR_W_DEF = 6;

    typedef enum logic [1:0] {
        OFS_SEL_16 = 2'b00,
        OFS_SEL_2  = 2'b01,
        OFS_SEL_8  = 2'b10,
        OFS_SEL_4  = 2'b11
    } ofs_sel_e;

    // Threshold offset chosen by the reset-time select code
    function automatic int unsigned ofs_preset(input logic [1:0] sel);
        case (ofs_sel_e'(sel))
            OFS_SEL_16: return 16;
            OFS_SEL_2:  return 2;
            OFS_SEL_8:  return 8;
            default:    return 4;
        endcase
    endfunction

endpackage

// File: rtl/afifo_ptr_sync.sv
`timescale 1ns/1ps
module afifo_ptr_sync #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign sync_out = st_q.s2;
endmodule

// File: rtl/afifo_ram.sv
`timescale 1ns/1ps
module afifo_ram #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Unregistered read; the read controller owns the output register
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/afifo_wr_ctl.sv
`timescale 1ns/1ps
module afifo_wr_ctl import afifo_pkg::*; #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic [1:0]        ofs_sel,
    input  logic              wen,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              full_n,
    output logic              afull_n
);
    localparam int unsigned   PW      = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [PW-1:0] ofs;
        logic          rdy;
    } st_t;

    st_t           st_d, st_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] level;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        rbin    = g2b(rgray_sync);
        level   = st_q.ptr - rbin;
        full_n  = st_q.rdy && (level != DEPTH_P);
        afull_n = level < (DEPTH_P - st_q.ofs);
        wr_fire = wen && full_n;

        st_d     = st_q;
        st_d.rdy = 1'b1;
        if (wr_fire) begin
            st_d.ptr  = st_q.ptr + PW'(1);
            st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        end
        if (!rst_n) begin
            st_d     = '0;
            st_d.ofs = PW'(ofs_preset(ofs_sel));
        end
    end

    always_ff @(posedge wclk) st_q <= st_d;

    assign waddr = st_q.ptr[ADDR_W-1:0];
    assign wgray = st_q.gray;

    // R4: a refused write leaves the write pointer where it was
    a_r4_full_blocks_write: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(st_q.ptr));

    // R10: the write-side word count never exceeds the depth
    a_r10_level_in_range: assert property (@(posedge wclk) disable iff (!rst_n)
        level <= DEPTH_P);

    // R6: a full buffer is always also almost full
    a_r6_full_implies_af: assert property (@(posedge wclk) disable iff (!rst_n)
        (st_q.rdy && !full_n) |-> !afull_n);

    // R2: the Gray pointer sent across changes by at most one bit per edge
    a_r2_gray_one_bit: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);
endmodule

// File: rtl/afifo_rd_ctl.sv
`timescale 1ns/1ps
module afifo_rd_ctl import afifo_pkg::*; #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [1:0]        ofs_sel,
    input  logic              ren,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] rdata,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int unsigned PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0]     ptr;
        logic [PW-1:0]     gray;
        logic [PW-1:0]     ofs;
        logic [DATA_W-1:0] dout;
    } st_t;

    st_t           st_d, st_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] level;
    logic          rd_fire;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        wbin     = g2b(wgray_sync);
        level    = wbin - st_q.ptr;
        empty_n  = level != '0;
        aempty_n = level > st_q.ofs;
        rd_fire  = ren && empty_n;

        st_d = st_q;
        if (rd_fire) begin
            st_d.ptr  = st_q.ptr + PW'(1);
            st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
            st_d.dout = mem_rdata;
        end
        if (!rst_n) begin
            st_d     = '0;
            st_d.ofs = PW'(ofs_preset(ofs_sel));
        end
    end

    always_ff @(posedge rclk) st_q <= st_d;

    assign raddr = st_q.ptr[ADDR_W-1:0];
    assign rgray = st_q.gray;
    assign rdata = st_q.dout;

    // R3: nothing moves on the read side while empty
    a_r3_empty_blocks_read: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> ($stable(st_q.ptr) && $stable(st_q.dout)));

    // R5: an empty buffer is always also almost empty
    a_r5_empty_implies_ae: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    // R2: the read pointer only ever advances by one
    a_r2_rptr_step: assert property (@(posedge rclk) disable iff (!rst_n)
        !$stable(st_q.ptr) |-> (st_q.ptr == $past(st_q.ptr) + PW'(1)));
endmodule

// File: rtl/afifo_sync_flags.sv
`timescale 1ns/1ps
module afifo_sync_flags import afifo_pkg::*; #(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [1:0]        ofs_sel,
    input  logic              wen,
    input  logic [DATA_W-1:0] wdata,
    output logic              full_n,
    output logic              afull_n,
    input  logic              ren,
    output logic [DATA_W-1:0] rdata,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int unsigned PW = ADDR_W + 1;

    logic              wr_fire;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_in_r;
    logic [PW-1:0]     rgray_in_w;
    logic [DATA_W-1:0] mem_rdata;

    afifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk  (wclk),
        .we    (wr_fire),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    afifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .wclk       (wclk),
        .rst_n      (rst_n),
        .ofs_sel    (ofs_sel),
        .wen        (wen),
        .rgray_sync (rgray_in_w),
        .wr_fire    (wr_fire),
        .waddr      (waddr),
        .wgray      (wgray),
        .full_n     (full_n),
        .afull_n    (afull_n)
    );

    afifo_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rclk       (rclk),
        .rst_n      (rst_n),
        .ofs_sel    (ofs_sel),
        .ren        (ren),
        .wgray_sync (wgray_in_r),
        .mem_rdata  (mem_rdata),
        .raddr      (raddr),
        .rgray      (rgray),
        .rdata      (rdata),
        .empty_n    (empty_n),
        .aempty_n   (aempty_n)
    );

    afifo_ptr_sync #(.W(PW)) u_w2r (
        .clk      (rclk),
        .rst_n    (rst_n),
        .async_in (wgray),
        .sync_out (wgray_in_r)
    );

    afifo_ptr_sync #(.W(PW)) u_r2w (
        .clk      (wclk),
        .rst_n    (rst_n),
        .async_in (rgray),
        .sync_out (rgray_in_w)
    );
endmodule

// File: tb/tb_afifo_sync_flags.sv
`timescale 1ns/1ps
module tb_afifo_sync_flags;

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ofs_sel = 2'b10;
    logic        wen = 1'b0;
    logic [35:0] wdata = '0;
    logic        ren = 1'b0;
    logic        full_n, afull_n, empty_n, aempty_n;
    logic [35:0] rdata;

    int checks = 0;
    int errors = 0;

    afifo_sync_flags dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wen(wen), .wdata(wdata), .full_n(full_n), .afull_n(afull_n),
        .ren(ren), .rdata(rdata), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    // 125 MHz write clock: rising edges at 4 + 8k ns
    always #4 wclk = ~wclk;
    // read clock, 10 ns period, rising edges at 3 + 10k ns (never on a wclk edge)
    initial begin
        #3 rclk = 1'b1;
        forever #5 rclk = ~rclk;
    end

    // vector: {sel[1:0], words[6:0], empty_n, aempty_n, full_n, afull_n}
    localparam int NV = 17;
    localparam logic [12:0] VEC [NV] = '{
        {2'b10, 7'd0,  4'b0011},
        {2'b10, 7'd8,  4'b1011},
        {2'b10, 7'd9,  4'b1111},
        {2'b10, 7'd55, 4'b1111},
        {2'b10, 7'd56, 4'b1110},
        {2'b01, 7'd2,  4'b1011},
        {2'b01, 7'd3,  4'b1111},
        {2'b01, 7'd61, 4'b1111},
        {2'b01, 7'd62, 4'b1110},
        {2'b00, 7'd16, 4'b1011},
        {2'b00, 7'd17, 4'b1111},
        {2'b00, 7'd48, 4'b1110},
        {2'b11, 7'd4,  4'b1011},
        {2'b11, 7'd5,  4'b1111},
        {2'b11, 7'd59, 4'b1111},
        {2'b11, 7'd60, 4'b1110},
        {2'b11, 7'd64, 4'b1100}
    };

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge wclk);
        rst_n = 1'b0; ofs_sel = s; wen = 1'b0; ren = 1'b0;
        repeat (6) @(negedge wclk);
        rst_n = 1'b1;
    endtask

    task automatic settle();
        repeat (4) @(posedge rclk);
        repeat (4) @(posedge wclk);
        #1;
    endtask

    task automatic write_burst(input int n, input logic [35:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wen = 1'b1; wdata = base + 36'(i);
        end
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic read_one(output logic [35:0] d);
        @(negedge rclk); ren = 1'b1;
        @(negedge rclk); ren = 1'b0;
        d = rdata;
    endtask

    initial begin
        #1_500_000;
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [35:0] d;
        logic [35:0] base;

        // R1: flag levels while reset is held
        repeat (6) @(negedge wclk);
        chk("R1 empty_n in reset", empty_n, 0);
        chk("R1 aempty_n in reset", aempty_n, 0);
        chk("R1 full_n in reset", full_n, 0);
        chk("R1 afull_n in reset", afull_n, 1);
        rst_n = 1'b1;
        settle();
        chk("R1 full_n after release", full_n, 1);

        // threshold table: R5 aempty, R6 afull, R10 full/empty, R7 preset codes
        for (int v = 0; v < NV; v++) begin
            do_reset(VEC[v][12:11]);
            settle();
            write_burst(int'(VEC[v][10:4]), 36'h0_1000_0000 * 36'(v));
            settle();
            chk("R10 empty_n level", empty_n, VEC[v][3]);
            chk("R5 R7 aempty_n level", aempty_n, VEC[v][2]);
            chk("R10 full_n level", full_n, VEC[v][1]);
            chk("R6 R7 afull_n level", afull_n, VEC[v][0]);
        end

        // R7: select changed after reset is not picked up (X stays 8)
        do_reset(2'b10);
        settle();
        @(negedge wclk); ofs_sel = 2'b00;
        write_burst(9, 36'h0_0000_0900);
        settle();
        chk("R7 aempty_n ignores late select", aempty_n, 1);

        // R8: empty flag latency after one write
        do_reset(2'b10);
        settle();
        @(negedge wclk); wen = 1'b1; wdata = 36'h5_A5A5_A5A5;
        @(posedge wclk); wen <= 1'b0;
        @(posedge rclk); #1;
        chk("R8 empty_n after 1st rclk edge", empty_n, 0);
        @(posedge rclk); #1;
        chk("R8 empty_n after 2nd rclk edge", empty_n, 1);
        read_one(d);
        chk("R2 single word data", d, 36'h5_A5A5_A5A5);

        // R10/R4/R9/R2: fill, overfill, full release latency, ordered drain
        do_reset(2'b11);
        settle();
        base = 36'hA_0000_0000;
        write_burst(64, base);
        settle();
        chk("R10 full_n at 64 words", full_n, 0);
        @(negedge wclk); wen = 1'b1; wdata = 36'hF_FFFF_FFFF;
        @(negedge wclk); wen = 1'b0;
        settle();
        @(negedge rclk); ren = 1'b1;
        @(posedge rclk); ren <= 1'b0;
        @(posedge wclk); #1;
        chk("R9 full_n after 1st wclk edge", full_n, 0);
        @(posedge wclk); #1;
        chk("R9 full_n after 2nd wclk edge", full_n, 1);
        chk("R2 first word out", rdata, base);
        for (int i = 1; i < 64; i++) begin
            read_one(d);
            chk("R2 drain order", d, base + 36'(i));
        end
        settle();
        chk("R4 overfill word dropped, empty", empty_n, 0);

        // R3: read on empty changes nothing
        read_one(d);
        chk("R3 rdata held on empty read", d, base + 36'd63);
        chk("R3 empty_n stays low", empty_n, 0);
        write_burst(1, 36'h1_2345_6789);
        settle();
        read_one(d);
        chk("R3 pointer did not skip", d, 36'h1_2345_6789);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule